// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog counter whose control registers can only be changed after a two-step key unlock on a simple register bus. Software first writes the value 0xBABA to one unlock register and then 0xEB10 to a second unlock register. Only after that does the next write to a protected register take effect. The unlock is spent by that single write, so every protected write needs a fresh key pair.

Once armed, the counter advances on each `tick_i` pulse. When it reaches the programmed match value it stops there and sets a status flag. If reset generation is also armed, it drives a reset request for a programmable number of clock cycles. Software restarts the count with a protected write to a restart register. It clears an earlier event with a protected write of 0 to the status register.

Top module: `keyguard_wdt`

## Requirements
- R1: After synchronous reset, the block reads back as follows: match value all ones, enable register 0, status 0, count 0 and pulse length 4. `wdt_rst_o` is low.
- R2: The register word addresses are:
  - 0: first key
  - 1: second key
  - 2: match value
  - 3: enable
  - 4: status
  - 5: count (read only)
  - 6: restart
  - 7: pulse length

  A write of 0xBABA to address 0, followed directly by a write of 0xEB10 to address 1, makes the next write to a protected address (2, 3, 4, 6 or 7) take effect.
- R3: The first write after an unlock consumes the unlock. Any write that is not the expected next key returns the unlock to locked; this includes a wrong value, a wrong address and keys out of order. Reads do not disturb the unlock.
- R4: A write to a protected address while locked is ignored and changes no register.
- R5: While enable bit 0 is set, each `tick_i` pulse increments the count until it equals the match value, and the count then holds there. While bit 0 is clear, ticks leave the count unchanged. A match value of 0 never fires.
- R6: When the count steps onto the match value, status bit 0 is set. An unlocked write to the status register with data bit 0 equal to 0 clears it. An unlocked write with bit 0 equal to 1 leaves it unchanged.
- R7: If enable bit 1 is set when the count steps onto the match value, `wdt_rst_o` goes high on that same clock edge. It stays high for the programmed pulse length in cycles; a length of 0 acts as 1.
- R8: An unlocked write of any value to the restart address sets the count to 0. A restart takes priority over a tick in the same cycle.
- R9: When `bus_re_i` is high, `bus_rdata_o` presents the addressed register on the following cycle. The key and restart addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we_i | input | 1 | Write strobe |
| bus_re_i | input | 1 | Read strobe |
| bus_addr_i | input | 3 | Register word address |
| bus_wdata_i | input | DW | Write data |
| bus_rdata_o | output | DW | Registered read data |
| tick_i | input | 1 | Count-advance pulse |
| wdt_rst_o | output | 1 | Reset request output |

## Verification
Several properties are checked on every cycle:
- the unlock state opens only from the half-unlocked state, and any write made while open closes it;
- the count only steps by one or returns to zero;
- the status flag rises only with the count at the match value, and falls only on a granted clear;
- the reset request rises only on a fire with reset generation armed.

Only the directed scenarios can show the behaviours that depend on software sequences:
- broken key sequences leave registers untouched;
- the fire lands after the exact number of ticks;
- the reset pulse lasts the programmed number of cycles.

// File: rtl/keyguard_pkg.sv
package keyguard_pkg;
  typedef enum logic [2:0] {
    RA_KEY1   = 3'd0,
    RA_KEY2   = 3'd1,
    RA_MATCH  = 3'd2,
    RA_ENABLE = 3'd3,
    RA_STATUS = 3'd4,
    RA_COUNT  = 3'd5,
    RA_RESTRT = 3'd6,
    RA_PLEN   = 3'd7
  } reg_addr_e;

  typedef enum logic [1:0] {
    LK_LOCKED = 2'd0,
    LK_HALF   = 2'd1,
    LK_OPEN   = 2'd2
  } lock_state_e;

  function automatic logic is_guarded(input logic [2:0] a);
    return (a == RA_MATCH) || (a == RA_ENABLE) || (a == RA_STATUS) ||
           (a == RA_RESTRT) || (a == RA_PLEN);
  endfunction
endpackage

// File: rtl/keyguard_unlock.sv
module keyguard_unlock
  import keyguard_pkg::*;
#(
  parameter int DW = 32,
  parameter logic [15:0] KEY_FIRST  = 16'hBABA,
  parameter logic [15:0] KEY_SECOND = 16'hEB10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [2:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic          grant
);
  localparam logic [DW-1:0] K1 = {{(DW-16){1'b0}}, KEY_FIRST};
  localparam logic [DW-1:0] K2 = {{(DW-16){1'b0}}, KEY_SECOND};

  lock_state_e state, state_nx;

  always_comb begin
    state_nx = state;
    if (we) begin
      if (addr == RA_KEY1 && wdata == K1)
        state_nx = LK_HALF;
      else if (state == LK_HALF && addr == RA_KEY2 && wdata == K2)
        state_nx = LK_OPEN;
      else
        state_nx = LK_LOCKED;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state <= LK_LOCKED;
    else     state <= state_nx;
  end

  assign grant = we && (state == LK_OPEN) && is_guarded(addr);

  AST_OPEN_ONLY_FROM_HALF: assert property (@(posedge clk) disable iff (rst)
    (state == LK_OPEN && $past(state) != LK_OPEN) |-> $past(state) == LK_HALF); // R2
  AST_UNLOCK_SINGLE_USE: assert property (@(posedge clk) disable iff (rst)
    (we && state == LK_OPEN) |=> state != LK_OPEN); // R3
  AST_READ_KEEPS_LOCK: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(state)); // R3
endmodule

// File: rtl/keyguard_counter.sv
module keyguard_counter #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          cnt_en,
  input  logic [CW-1:0] limit,
  input  logic          restart,
  input  logic          flag_clr,
  output logic [CW-1:0] cnt,
  output logic          flag,
  output logic          fire
);
  logic [CW-1:0] cnt_inc;
  logic          at_limit;

  assign cnt_inc  = cnt + CW'(1);
  assign at_limit = (cnt == limit);
  assign fire     = tick && cnt_en && !restart && !at_limit && (cnt_inc == limit);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (restart) begin
      cnt <= '0;
    end else if (tick && cnt_en && !at_limit) begin
      cnt <= cnt_inc;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           flag <= 1'b0;
    else if (fire)     flag <= 1'b1;
    else if (flag_clr) flag <= 1'b0;
  end

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    !$stable(cnt) |-> (cnt == '0 || cnt == $past(cnt) + CW'(1))); // R5
  AST_FLAG_AT_MATCH: assert property (@(posedge clk) disable iff (rst)
    $rose(flag) |-> cnt == limit); // R6
  AST_FLAG_CLEAR_GRANTED: assert property (@(posedge clk) disable iff (rst)
    $fell(flag) |-> $past(flag_clr)); // R6
endmodule

// File: rtl/keyguard_pulse.sv
module keyguard_pulse #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fire,
  input  logic          rst_en,
  input  logic [PW-1:0] plen,
  output logic          rst_req
);
  logic [PW-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      rst_req <= 1'b0;
      remain  <= '0;
    end else if (fire && rst_en) begin
      rst_req <= 1'b1;
      remain  <= (plen == '0) ? '0 : plen - PW'(1);
    end else if (remain != '0) begin
      remain  <= remain - PW'(1);
    end else begin
      rst_req <= 1'b0;
    end
  end

  AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_req) |-> $past(fire && rst_en)); // R7
  AST_PULSE_NO_STRAY: assert property (@(posedge clk) disable iff (rst)
    (!rst_req && !(fire && rst_en)) |=> !rst_req); // R7
endmodule

// File: rtl/keyguard_wdt.sv
module keyguard_wdt
  import keyguard_pkg::*;
#(
  parameter int DW = 32,
  parameter int CW = 32,
  parameter int PW = 8,
  parameter int PLEN_RESET = 4,
  parameter logic [15:0] KEY_FIRST  = 16'hBABA,
  parameter logic [15:0] KEY_SECOND = 16'hEB10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_we_i,
  input  logic          bus_re_i,
  input  logic [2:0]    bus_addr_i,
  input  logic [DW-1:0] bus_wdata_i,
  output logic [DW-1:0] bus_rdata_o,
  input  logic          tick_i,
  output logic          wdt_rst_o
);
  logic          grant;
  logic [CW-1:0] match_q;
  logic [1:0]    enable_q;
  logic [PW-1:0] plen_q;
  logic [CW-1:0] cnt;
  logic          flag;
  logic          fire;
  logic          restart;
  logic          flag_clr;

  keyguard_unlock #(.DW(DW), .KEY_FIRST(KEY_FIRST), .KEY_SECOND(KEY_SECOND)) u_unlock (
    .clk(clk), .rst(rst), .we(bus_we_i), .addr(bus_addr_i),
    .wdata(bus_wdata_i), .grant(grant)
  );

  assign restart  = grant && (bus_addr_i == RA_RESTRT);
  assign flag_clr = grant && (bus_addr_i == RA_STATUS) && !bus_wdata_i[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      match_q  <= '1;
      enable_q <= 2'b00;
      plen_q   <= PW'(PLEN_RESET);
    end else if (grant) begin
      case (bus_addr_i)
        RA_MATCH:  match_q  <= bus_wdata_i[CW-1:0];
        RA_ENABLE: enable_q <= bus_wdata_i[1:0];
        RA_PLEN:   plen_q   <= bus_wdata_i[PW-1:0];
        default: ;
      endcase
    end
  end

  keyguard_counter #(.CW(CW)) u_counter (
    .clk(clk), .rst(rst), .tick(tick_i), .cnt_en(enable_q[0]),
    .limit(match_q), .restart(restart), .flag_clr(flag_clr),
    .cnt(cnt), .flag(flag), .fire(fire)
  );

  keyguard_pulse #(.PW(PW)) u_pulse (
    .clk(clk), .rst(rst), .fire(fire), .rst_en(enable_q[1]),
    .plen(plen_q), .rst_req(wdt_rst_o)
  );

  logic [DW-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    case (bus_addr_i)
      RA_MATCH:  rd_mux[CW-1:0] = match_q;
      RA_ENABLE: rd_mux[1:0]    = enable_q;
      RA_STATUS: rd_mux[0]      = flag;
      RA_COUNT:  rd_mux[CW-1:0] = cnt;
      RA_PLEN:   rd_mux[PW-1:0] = plen_q;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)           bus_rdata_o <= '0;
    else if (bus_re_i) bus_rdata_o <= rd_mux;
  end

  AST_LOCKED_MATCH_STABLE: assert property (@(posedge clk) disable iff (rst)
    !grant |=> $stable(match_q)); // R4
endmodule

// File: tb/keyguard_wdt_tb_top.sv
module keyguard_wdt_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_we = 1'b0, bus_re = 1'b0, tick = 1'b0;
  logic [2:0]    bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          wdt_rst;

  int n_checks = 0;
  int n_fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  keyguard_wdt dut_i (
    .clk(clk), .rst(rst), .bus_we_i(bus_we), .bus_re_i(bus_re),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .tick_i(tick), .wdt_rst_o(wdt_rst)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
    @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [DW-1:0] d);
    @(negedge clk); bus_re = 1'b1; bus_addr = a;
    @(negedge clk); bus_re = 1'b0; d = bus_rdata;
  endtask

  task automatic kwr(input logic [2:0] a, input logic [DW-1:0] d);
    wr(3'd0, 32'h0000_BABA);
    wr(3'd1, 32'h0000_EB10);
    wr(a, d);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic pulse_width(output int w);
    w = 0;
    while (wdt_rst && w < 300) begin
      w++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    logic [DW-1:0] v;
    rd(3'd2, v); check("R1 match reset", v, 32'hFFFF_FFFF);
    rd(3'd3, v); check("R1 enable reset", v, 0);
    rd(3'd4, v); check("R1 status reset", v, 0);
    rd(3'd5, v); check("R9/R1 count reset", v, 0);
    rd(3'd7, v); check("R1 plen reset", v, 4);
    check("R1 rst_o reset", {31'd0, wdt_rst}, 0);
  endtask

  task automatic t_locking;
    logic [DW-1:0] v;
    wr(3'd2, 32'h5);
    rd(3'd2, v); check("R4 locked write ignored", v, 32'hFFFF_FFFF);
    kwr(3'd2, 32'hF);
    rd(3'd2, v); check("R2 keyed write applied", v, 32'hF);
    wr(3'd2, 32'h7);
    rd(3'd2, v); check("R3 unlock used up", v, 32'hF);
    wr(3'd0, 32'h0000_BABA); wr(3'd1, 32'h0000_EB11); wr(3'd2, 32'h8);
    rd(3'd2, v); check("R3 wrong second key", v, 32'hF);
    wr(3'd1, 32'h0000_EB10); wr(3'd0, 32'h0000_BABA); wr(3'd2, 32'h9);
    rd(3'd2, v); check("R3 keys out of order", v, 32'hF);
    wr(3'd0, 32'h0000_BABA); wr(3'd7, 32'h2); wr(3'd1, 32'h0000_EB10); wr(3'd2, 32'hA);
    rd(3'd2, v); check("R3 interposed write breaks unlock", v, 32'hF);
    rd(3'd7, v); check("R4 plen untouched", v, 4);
    wr(3'd0, 32'h0000_BABA); wr(3'd1, 32'h0000_EB10); rd(3'd5, v); wr(3'd2, 32'hB);
    rd(3'd2, v); check("R3 read keeps unlock", v, 32'hB);
    rd(3'd0, v); check("R9 key reads zero", v, 0);
    kwr(3'd2, 32'hF);
  endtask

  task automatic t_count;
    logic [DW-1:0] v;
    ticks(3);
    rd(3'd5, v); check("R5 disabled no count", v, 0);
    kwr(3'd3, 32'h1);
    ticks(14);
    rd(3'd5, v); check("R5 count 14", v, 14);
    rd(3'd4, v); check("R6 no flag before match", v, 0);
    ticks(1);
    rd(3'd4, v); check("R6 flag at match", v, 1);
    rd(3'd5, v); check("R5 count at match", v, 15);
    check("R7 no reset without bit1", {31'd0, wdt_rst}, 0);
    ticks(3);
    rd(3'd5, v); check("R5 holds at match", v, 15);
    wr(3'd4, 32'h0);
    rd(3'd4, v); check("R4 locked clear ignored", v, 1);
    kwr(3'd4, 32'h1);
    rd(3'd4, v); check("R6 write 1 keeps flag", v, 1);
    kwr(3'd4, 32'h0);
    rd(3'd4, v); check("R6 flag cleared", v, 0);
    wr(3'd6, 32'h0);
    rd(3'd5, v); check("R4 locked restart ignored", v, 15);
    kwr(3'd6, 32'h0);
    rd(3'd5, v); check("R8 restart clears count", v, 0);
  endtask

  task automatic t_pulse;
    logic [DW-1:0] v;
    int w;
    kwr(3'd7, 32'h3);
    kwr(3'd2, 32'h4);
    kwr(3'd3, 32'h3);
    ticks(3);
    check("R7 no reset before match", {31'd0, wdt_rst}, 0);
    ticks(1);
    pulse_width(w);
    check("R7 pulse width 3", DW'(w), 3);
    rd(3'd4, v); check("R6 flag with reset", v, 1);
    kwr(3'd7, 32'h0);
    kwr(3'd6, 32'h0);
    kwr(3'd4, 32'h0);
    ticks(4);
    pulse_width(w);
    check("R7 zero length acts as 1", DW'(w), 1);
    kwr(3'd2, 32'h0);
    kwr(3'd6, 32'h0);
    ticks(5);
    rd(3'd5, v); check("R5 match zero holds", v, 0);
    check("R5 match zero no fire", {31'd0, wdt_rst}, 0);
  endtask

  task automatic t_restart_priority;
    logic [DW-1:0] v;
    kwr(3'd2, 32'h10);
    kwr(3'd3, 32'h1);
    ticks(2);
    wr(3'd0, 32'h0000_BABA); wr(3'd1, 32'h0000_EB10);
    @(negedge clk); bus_we = 1'b1; bus_addr = 3'd6; bus_wdata = 0; tick = 1'b1;
    @(negedge clk); bus_we = 1'b0; tick = 1'b0;
    rd(3'd5, v); check("R8 restart beats tick", v, 0);
  endtask

  initial begin
    fork
      begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_locking();
        t_count();
        t_pulse();
        t_restart_priority();
      end
      begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fails++;
        $display("FAIL watchdog timeout actual=running expected=done");
      end
    join_any
    disable fork;
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule